// File: doc/BRIEF.md
# Clock Multiplier Configuration Controller

This block is the digital control logic that sits beside an on-chip clock-multiplier PLL. It decides which source sets the multiplication factor and turns the requested code into a factor the PLL can use. It also reports when the PLL may be treated as settled. Out of reset, five strap pins choose the factor. The first read or write on the register bus hands control to two byte-wide registers for the rest of the run. One register holds the PLL enable. The other holds the requested 6-bit factor code and the automatic band-select enable, and shows a read-only lock indicator.

A requested code does not reach the PLL directly. It is rounded down to the nearest factor that the PLL supports, and the result is clamped between 8 and 42. Under register control, the effective factor is captured only at the moment the enable bit goes from 0 to 1. To apply a new code, software must therefore clear the enable and set it again. In strap mode, the all-ones strap pattern selects pass-through: the PLL is off and the reference clock is used as the modulator clock. Lock is modelled by a counter of reference-clock cycles, because the analog loop is not part of this block.

Top module: `clkmul_ctrl`

## Requirements
- R1: After reset, every output reads zero: `effFactor`, `pllEnable`, `bandSelEn`, `bypass`, `locked` and `regRdata`. The block starts in strap mode.
- R2: In strap mode, one cycle after the straps are sampled, `pllEnable` is 1 and `effFactor` is the quantized value of the 5-bit strap code. This applies to every strap value other than all-ones.
- R3: In strap mode, a strap value of 5'b11111 makes `bypass` 1, `pllEnable` 0, `locked` 0 and `effFactor` 1, one cycle after it is sampled.
- R4: The first cycle with `regWr` or `regRd` asserted switches the block to register mode for good. From that point `bypass` is 0 and the straps have no effect on any output.
- R5: Address 0x09, bit 2, is the PLL enable. Address 0x0A, bits [5:0], is the requested code, and bit 6 is the band-select enable, which drives `bandSelEn`. Writes take effect one cycle after the write strobe.
- R6: Quantization maps a code to the largest member of {8,9,10,12,14,15,16,17,18,20,21,24,25,28,30,32,34,42} that does not exceed it. Codes 0 to 8 give 8, and codes of 42 and above give 42.
- R7: In register mode, `effFactor` changes only on a write to 0x09 that sets bit 2 while the enable bit is 0. At that point it takes the quantized current code. Code writes made while the enable is set leave it unchanged.
- R8: `locked` rises exactly LOCK_CYCLES cycles after `pllEnable` rises, provided `pllEnable` stays high throughout. It falls in the same cycle that `pllEnable` falls.
- R9: A read returns its data on `regRdata` one cycle after `regRd`, and the value holds until the next read. Address 0x09 reads {5'b0, enable, 2'b0}. Address 0x0A reads {locked, band, code}, and bit 7 ignores writes. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; also the lock counter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register bus address |
| regWdata | input | 8 | Register bus write data |
| regWr | input | 1 | Write strobe, one cycle per write |
| regRd | input | 1 | Read strobe, one cycle per read |
| regRdata | output | 8 | Registered read data |
| strapPins | input | 5 | External factor straps |
| effFactor | output | 6 | Effective multiplication factor (1 in pass-through) |
| pllEnable | output | 1 | PLL enable |
| bandSelEn | output | 1 | Automatic band-select enable |
| bypass | output | 1 | Reference clock passed straight through |
| locked | output | 1 | PLL lock flag |

## Verification
The assertions check four things on every cycle. Lock never shows without the enable. Pass-through never coexists with the enable or with lock. An enabled factor always lies between 8 and 42. Once register mode is active, the factor holds steady while the enable stays high, pass-through can no longer appear, and lock rises only after the full count of enabled cycles. Only the bench scenarios can show the rest: the exact quantization of every code, the re-latch on a disable and enable sequence, that straps are ignored after the hand-over, and the read-back contents, including the ignored lock-bit write and the zero from unmapped addresses.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;
  localparam int DATA_W    = 8;
  localparam int CODE_W    = 6;
  localparam int STRAP_W   = 5;
  localparam int EN_BIT    = 2;
  localparam int BAND_BIT  = 6;
  localparam int LOCK_BIT  = 7;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CFG  = 2'd2
  } rdSel_t;

  typedef struct packed {
    logic   wrEnable;
    logic   wrConfig;
    logic   latchFactor;
    logic   rdStrobe;
    rdSel_t rdSel;
    logic   regMode;
  } ctrlStrobes_t;

  // Round a requested code down to the nearest supported factor.
  function automatic logic [CODE_W-1:0] quantize(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] f;
    if      (c >= 6'd42) f = 6'd42;
    else if (c >= 6'd34) f = 6'd34;
    else if (c >= 6'd32) f = 6'd32;
    else if (c >= 6'd30) f = 6'd30;
    else if (c >= 6'd28) f = 6'd28;
    else if (c >= 6'd25) f = 6'd25;
    else if (c >= 6'd24) f = 6'd24;
    else if (c >= 6'd21) f = 6'd21;
    else if (c >= 6'd20) f = 6'd20;
    else if (c >= 6'd18) f = 6'd18;
    else if (c >= 6'd14) f = c;
    else if (c >= 6'd12) f = 6'd12;
    else if (c >= 6'd10) f = 6'd10;
    else if (c == 6'd9)  f = 6'd9;
    else                 f = 6'd8;
    return f;
  endfunction
endpackage

// File: rtl/clkmul_ctrl_fsm.sv
module clkmul_ctrl_fsm
  import clkmul_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 'h09,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'h0A
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              enBit,
  output ctrlStrobes_t      strobes
);
  logic regModeQ;
  logic hitEn;
  logic hitCfg;

  assign hitEn  = (regAddr == EN_ADDR);
  assign hitCfg = (regAddr == CFG_ADDR);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) regModeQ <= 1'b0;
    else if (regWr || regRd) regModeQ <= 1'b1;
  end

  always_comb begin
    strobes.wrEnable    = regWr && hitEn;
    strobes.wrConfig    = regWr && hitCfg;
    strobes.latchFactor = regWr && hitEn && regWdata[EN_BIT] && !enBit;
    strobes.rdStrobe    = regRd;
    if (hitEn)       strobes.rdSel = SEL_EN;
    else if (hitCfg) strobes.rdSel = SEL_CFG;
    else             strobes.rdSel = SEL_NONE;
    strobes.regMode     = regModeQ;
  end
endmodule

// File: rtl/clkmul_datapath.sv
module clkmul_datapath
  import clkmul_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024,
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic               refClk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [STRAP_W-1:0] strapPins,
  output logic               enBit,
  output logic [DATA_W-1:0]  regRdata,
  output logic [CODE_W-1:0]  effFactor,
  output logic               pllEnable,
  output logic               bandSelEn,
  output logic               bypass,
  output logic               locked
);
  localparam logic [CNT_W-1:0] LOCK_LIM = CNT_W'(LOCK_CYCLES);

  logic [CODE_W-1:0] codeReg;
  logic              bandBit;
  logic [CODE_W-1:0] latchedFactor;
  logic              pinEn;
  logic              pinByp;
  logic [CODE_W-1:0] pinFactor;
  logic [CNT_W-1:0]  lockCnt;
  logic              strapAllOnes;
  logic [DATA_W-1:0] rdMux;

  assign strapAllOnes = &strapPins;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      enBit         <= 1'b0;
      codeReg       <= '0;
      bandBit       <= 1'b0;
      latchedFactor <= '0;
      pinEn         <= 1'b0;
      pinByp        <= 1'b0;
      pinFactor     <= '0;
    end else begin
      if (strobes.wrEnable) enBit <= regWdata[EN_BIT];
      if (strobes.wrConfig) begin
        codeReg <= regWdata[CODE_W-1:0];
        bandBit <= regWdata[BAND_BIT];
      end
      if (strobes.latchFactor) latchedFactor <= quantize(codeReg);
      pinEn     <= !strapAllOnes;
      pinByp    <= strapAllOnes;
      pinFactor <= strapAllOnes ? CODE_W'(1) : quantize({1'b0, strapPins});
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)              lockCnt <= '0;
    else if (!pllEnable)    lockCnt <= '0;
    else if (lockCnt != LOCK_LIM) lockCnt <= lockCnt + 1'b1;
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_EN:  rdMux = DATA_W'({enBit, 2'b00});
      SEL_CFG: rdMux = {locked, bandBit, codeReg};
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                 regRdata <= '0;
    else if (strobes.rdStrobe) regRdata <= rdMux;
  end

  assign pllEnable = strobes.regMode ? enBit : pinEn;
  assign bypass    = !strobes.regMode && pinByp;
  assign effFactor = strobes.regMode ? latchedFactor : pinFactor;
  assign bandSelEn = bandBit;
  assign locked    = pllEnable && (lockCnt == LOCK_LIM);
endmodule

// File: rtl/clkmul_ctrl.sv
module clkmul_ctrl
  import clkmul_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LOCK_CYCLES = 1024
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  logic              regWr,
  input  logic              regRd,
  output logic [7:0]        regRdata,
  input  logic [4:0]        strapPins,
  output logic [5:0]        effFactor,
  output logic              pllEnable,
  output logic              bandSelEn,
  output logic              bypass,
  output logic              locked
);
  ctrlStrobes_t strobes;
  logic         enBit;

  clkmul_ctrl_fsm #(
    .ADDR_W  (ADDR_W),
    .EN_ADDR (ADDR_W'('h09)),
    .CFG_ADDR(ADDR_W'('h0A))
  ) u_ctrl (
    .refClk  (refClk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regWr   (regWr),
    .regRd   (regRd),
    .enBit   (enBit),
    .strobes (strobes)
  );

  clkmul_datapath #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_dp (
    .refClk   (refClk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWdata (regWdata),
    .strapPins(strapPins),
    .enBit    (enBit),
    .regRdata (regRdata),
    .effFactor(effFactor),
    .pllEnable(pllEnable),
    .bandSelEn(bandSelEn),
    .bypass   (bypass),
    .locked   (locked)
  );
endmodule

// File: rtl/clkmul_ctrl_chk.sv
module clkmul_ctrl_chk #(
  parameter int LOCK_CYCLES = 1024
) (
  input logic       refClk,
  input logic       rstN,
  input logic       regWr,
  input logic       regRd,
  input logic [5:0] effFactor,
  input logic       pllEnable,
  input logic       bypass,
  input logic       locked
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  logic          modeSeen;
  logic [CW-1:0] hiCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      modeSeen <= 1'b0;
      hiCnt    <= '0;
    end else begin
      if (regWr || regRd) modeSeen <= 1'b1;
      if (!pllEnable) hiCnt <= '0;
      else if (hiCnt != CW'(LOCK_CYCLES)) hiCnt <= hiCnt + 1'b1;
    end
  end

  assert_lock_needs_enable_R8: assert property (@(posedge refClk) disable iff (!rstN)
    locked |-> pllEnable);

  assert_lock_after_count_R8: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(locked) |-> (hiCnt == CW'(LOCK_CYCLES)));

  assert_bypass_exclusive_R3: assert property (@(posedge refClk) disable iff (!rstN)
    bypass |-> (!pllEnable && !locked));

  assert_factor_range_R6: assert property (@(posedge refClk) disable iff (!rstN)
    pllEnable |-> (effFactor >= 6'd8 && effFactor <= 6'd42));

  assert_no_bypass_regmode_R4: assert property (@(posedge refClk) disable iff (!rstN)
    modeSeen |-> !bypass);

  assert_factor_held_R7: assert property (@(posedge refClk) disable iff (!rstN)
    (modeSeen && $past(modeSeen) && pllEnable && $past(pllEnable)) |-> $stable(effFactor));
endmodule

bind clkmul_ctrl clkmul_ctrl_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .refClk   (refClk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regRd    (regRd),
  .effFactor(effFactor),
  .pllEnable(pllEnable),
  .bypass   (bypass),
  .locked   (locked)
);

// File: tb/clkmul_ctrl_tb.sv
`timescale 1ns/1ps
module clkmul_ctrl_tb;
  localparam int LOCK = 1024;

  logic       refClk = 1'b0;
  logic       rstN   = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regRdata;
  logic [4:0] strapPins = 5'd0;
  logic [5:0] effFactor;
  logic       pllEnable, bandSelEn, bypass, locked;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  always #4 refClk = ~refClk;

  clkmul_ctrl u_dut (
    .refClk(refClk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWr(regWr), .regRd(regRd), .regRdata(regRdata), .strapPins(strapPins),
    .effFactor(effFactor), .pllEnable(pllEnable), .bandSelEn(bandSelEn),
    .bypass(bypass), .locked(locked)
  );

  // Reference model state
  int mMode, mEn, mBand, mCode, mLat, mPinEn, mPinByp, mPinFac, mCnt, mRd;
  int supported[$] = '{42, 34, 32, 30, 28, 25, 24, 21, 20, 18, 17, 16, 15, 14, 12, 10, 9, 8};

  function automatic int refQuant(int c);
    foreach (supported[i]) if (c >= supported[i]) return supported[i];
    return 8;
  endfunction

  function automatic int curEn();
    return mMode ? mEn : mPinEn;
  endfunction

  function automatic int curLock();
    return (curEn() != 0 && mCnt == LOCK) ? 1 : 0;
  endfunction

  always @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mEn = 0; mBand = 0; mCode = 0; mLat = 0;
      mPinEn = 0; mPinByp = 0; mPinFac = 0; mCnt = 0; mRd = 0;
    end else begin
      int enNow, lkNow;
      enNow = curEn();
      lkNow = curLock();
      if (regRd) begin
        if (regAddr == 8'h09)      mRd = mEn * 4;
        else if (regAddr == 8'h0A) mRd = lkNow * 128 + mBand * 64 + mCode;
        else                       mRd = 0;
      end
      if (regWr && regAddr == 8'h09) begin
        if (regWdata[2] && mEn == 0) mLat = refQuant(mCode);
        mEn = regWdata[2];
      end
      if (regWr && regAddr == 8'h0A) begin
        mCode = regWdata & 8'h3F;
        mBand = regWdata[6];
      end
      mPinByp = (strapPins == 5'h1F);
      mPinEn  = !mPinByp;
      mPinFac = mPinByp ? 1 : refQuant(strapPins);
      if (enNow == 0) mCnt = 0;
      else if (mCnt < LOCK) mCnt = mCnt + 1;
      if (regWr || regRd) mMode = 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge refClk) begin
    if (rstN && !done) begin
      check("R2", "pllEnable", pllEnable, curEn());
      check("R3", "bypass", bypass, mMode ? 0 : mPinByp);
      check("R8", "locked", locked, curLock());
      check("R5", "bandSelEn", bandSelEn, mBand);
      check("R6", "effFactor", effFactor, mMode ? mLat : mPinFac);
      check("R9", "regRdata", regRdata, mRd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic wrReg(logic [7:0] a, logic [7:0] d);
    @(negedge refClk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge refClk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a);
    @(negedge refClk);
    regAddr = a; regRd = 1'b1;
    @(negedge refClk);
    regRd = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge refClk);
    nBad++;
    nCmp++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    strapPins = 5'd11;
    repeat (3) @(negedge refClk);
    // R1: reset state
    check("R1", "effFactor", effFactor, 0);
    check("R1", "pllEnable", pllEnable, 0);
    check("R1", "bypass", bypass, 0);
    check("R1", "locked", locked, 0);
    check("R1", "bandSelEn", bandSelEn, 0);
    check("R1", "regRdata", regRdata, 0);
    rstN = 1'b1;
    idle(2);
    // R2: strap codes decoded and quantized
    check("R2", "strap 11 factor", effFactor, 10);
    strapPins = 5'd19; idle(2);
    check("R2", "strap 19 factor", effFactor, 18);
    strapPins = 5'd0;  idle(2);
    check("R2", "strap 0 factor", effFactor, 8);
    strapPins = 5'd26; idle(2);
    check("R2", "strap 26 factor", effFactor, 25);
    // R8: lock in strap mode
    idle(LOCK + 4);
    check("R8", "strap-mode lock", locked, 1);
    // R3: all-ones straps give pass-through
    strapPins = 5'h1F; idle(2);
    check("R3", "bypass", bypass, 1);
    check("R3", "lock cleared", locked, 0);
    check("R3", "factor one", effFactor, 1);
    strapPins = 5'd13; idle(3);
    // R4: first access hands control to registers
    rdReg(8'h0A);
    idle(1);
    check("R4", "enable after handover", pllEnable, 0);
    strapPins = 5'h1F; idle(3);
    check("R4", "straps ignored bypass", bypass, 0);
    strapPins = 5'd5; idle(2);
    check("R4", "straps ignored factor", effFactor, 0);
    // R5/R7: program code then enable
    wrReg(8'h0A, 8'h4D);   // code 13, band on
    check("R5", "band select", bandSelEn, 1);
    wrReg(8'h09, 8'h04);
    check("R7", "latched 13", effFactor, 12);
    idle(LOCK + 2);
    rdReg(8'h0A); idle(1);
    check("R9", "lock bit readback", regRdata, 8'hCD);
    // R7: code change while enabled has no effect
    wrReg(8'h0A, 8'h28);   // code 40
    idle(3);
    check("R7", "factor held", effFactor, 12);
    wrReg(8'h09, 8'h04);   // enable already set: no re-latch
    check("R7", "no relatch", effFactor, 12);
    wrReg(8'h09, 8'h00);
    check("R8", "lock drops with enable", locked, 0);
    wrReg(8'h09, 8'h04);
    check("R7", "relatch 40", effFactor, 34);
    // R9: lock bit write ignored, unmapped read zero, enable readback
    wrReg(8'h09, 8'h00);
    wrReg(8'h0A, 8'hFF);
    rdReg(8'h0A); idle(1);
    check("R9", "lock bit not writable", regRdata, 8'h7F);
    rdReg(8'h33); idle(1);
    check("R9", "unmapped read", regRdata, 0);
    wrReg(8'h09, 8'hFF);
    rdReg(8'h09); idle(1);
    check("R9", "enable readback", regRdata, 8'h04);
    check("R6", "code 63 saturates", effFactor, 42);
    // R6: sweep every code
    for (int c = 0; c < 64; c++) begin
      wrReg(8'h09, 8'h00);
      wrReg(8'h0A, c[7:0] & 8'h3F);
      wrReg(8'h09, 8'h04);
      check("R6", "sweep factor", effFactor, refQuant(c));
    end
    idle(4);
    finishRun();
  end
endmodule